// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned 16-bit operands and gives a 32-bit product. It handles one multiplier bit per clock cycle. An auxiliary accumulator collects the partial products. At each step, the accumulator and the remaining multiplier bits shift right together. After sixteen steps, the accumulator holds the upper half of the product and the shifted multiplier register holds the lower half.

The product is meant to be written back to a pair of registers. The requested destination index is forced even by clearing its bit 0. The partner index is that even index with bit 0 inverted. The upper half of the product goes to the even register and the lower half goes to the odd one.

A caller pulses the start input for one cycle with the operands and the destination index. The caller then waits for the one-cycle completion pulse and reads the product halves and the two indices.

Top module: `shift_add_mul`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the multiplier register, the step counter, busy and done. After reset, both product halves read zero, the even index reads 0 and the odd index reads 1.
- R2: When start is high at a clock edge and the block is idle, that edge accepts the operands and the destination index. Busy is high from the following cycle.
- R3: Done goes high exactly 16 clock edges after the accepting edge. Busy is high for exactly those 16 cycles.
- R4: When done is high, the upper output word equals bits 31..16 and the lower output word equals bits 15..0 of the unsigned product of the accepted operands.
- R5: The even index output is the accepted index with bit 0 cleared. The odd index output equals the even index with bit 0 inverted. Both are updated at the accepting edge.
- R6: A start while busy is ignored. The running operation's product, indices and completion time are unchanged.
- R7: While idle and without a new start, the product halves and indices hold their values.
- R8: Done lasts exactly one cycle, and busy is low whenever done is high.
- R9: A start in the same cycle as done is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, sampled when idle |
| mcand_i | input | 16 | Multiplicand |
| mplier_i | input | 16 | Multiplier |
| rd_i | input | 4 | Requested destination register index |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prod_hi_o | output | 16 | Upper product word, for the even register |
| prod_lo_o | output | 16 | Lower product word, for the odd register |
| rd_even_o | output | 4 | Even destination index |
| rd_odd_o | output | 4 | Odd partner index |

## Verification
The assertions assume start is a clean value at each edge and that the operand and index inputs are sampled only at the accepting edge. The completion-timing check counts cycles from that edge, so it also assumes reset is not raised in the middle of an operation.

The stimulus drives every input on the falling edge. It holds start for a single cycle, except for a deliberate pulse raised during a running operation. It asserts reset only before any operation begins. Operands include zero, all ones, one, fixed patterns and pseudo-random values, and destination indices include odd values.

// File: rtl/mul_pkg.sv
package mul_pkg;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 4;
    localparam int PROD_W = 2 * DATA_W;
    localparam int CNT_W  = $clog2(DATA_W);

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} mul_state_t;

    typedef struct packed {
        logic [IDX_W-1:0] even;
        logic [IDX_W-1:0] odd;
    } reg_pair_t;

    function automatic reg_pair_t pair_of(input logic [IDX_W-1:0] rd);
        reg_pair_t p;
        p.even = {rd[IDX_W-1:1], 1'b0};
        p.odd  = p.even ^ IDX_W'(1);
        return p;
    endfunction
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import mul_pkg::*;
#(
    parameter int STEPS = DATA_W
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    mul_state_t state_q;
    logic [CW-1:0] cnt_q;
    logic done_q;

    assign load = start && (state_q == ST_IDLE);
    assign step = (state_q == ST_RUN);
    assign busy = step;
    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                default: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
    import mul_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    logic [W-1:0] acc_q, mq_q, mc_q;
    logic [W:0]   sum;

    always_comb begin
        sum = {1'b0, acc_q} + (mq_q[0] ? {1'b0, mc_q} : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            mq_q  <= '0;
            mc_q  <= '0;
        end else if (load) begin
            acc_q <= '0;
            mq_q  <= mplier;
            mc_q  <= mcand;
        end else if (step) begin
            acc_q <= sum[W:1];
            mq_q  <= {sum[0], mq_q[W-1:1]};
        end
    end

    assign hi = acc_q;
    assign lo = mq_q;
endmodule

// File: rtl/mul_pair_idx.sv
module mul_pair_idx
    import mul_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] rd,
    output reg_pair_t        pair
);
    reg_pair_t pair_q;

    always_ff @(posedge clk) begin
        if (rst)       pair_q <= pair_of('0);
        else if (load) pair_q <= pair_of(rd);
    end

    assign pair = pair_q;
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
    import mul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DATA_W-1:0] mcand_i,
    input  logic [DATA_W-1:0] mplier_i,
    input  logic [IDX_W-1:0]  rd_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] prod_hi_o,
    output logic [DATA_W-1:0] prod_lo_o,
    output logic [IDX_W-1:0]  rd_even_o,
    output logic [IDX_W-1:0]  rd_odd_o
);
    logic load, step;
    reg_pair_t pair;

    mul_ctrl #(.STEPS(DATA_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start_i),
        .load(load), .step(step), .busy(busy_o), .done(done_o)
    );

    mul_datapath #(.W(DATA_W)) u_dp (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .mcand(mcand_i), .mplier(mplier_i),
        .hi(prod_hi_o), .lo(prod_lo_o)
    );

    mul_pair_idx u_pair (
        .clk(clk), .rst(rst), .load(load), .rd(rd_i), .pair(pair)
    );

    assign rd_even_o = pair.even;
    assign rd_odd_o  = pair.odd;
endmodule

// File: rtl/mul_checker.sv
module mul_checker
    import mul_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [DATA_W-1:0] prod_hi_o,
    input logic [DATA_W-1:0] prod_lo_o,
    input logic [IDX_W-1:0]  rd_even_o,
    input logic [IDX_W-1:0]  rd_odd_o
);
    logic [CNT_W:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst)                     busy_len <= '0;
        else if (start_i && !busy_o) busy_len <= '0;
        else if (busy_o)             busy_len <= busy_len + 1'b1;
    end

    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    p_done_timing_r3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (busy_len == (CNT_W+1)'(DATA_W)));

    p_pair_shape_r5: assert property (@(posedge clk) disable iff (rst)
        !rd_even_o[0] && $countones(rd_even_o ^ rd_odd_o) == 1 && rd_odd_o[0]);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(prod_hi_o) && $stable(prod_lo_o)
                                   && $stable(rd_even_o)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    p_busy_keeps_index_r6: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(rd_even_o));
endmodule

bind shift_add_mul mul_checker u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o),
    .rd_even_o(rd_even_o), .rd_odd_o(rd_odd_o)
);

// File: tb/tb_shift_add_mul.sv
module tb_shift_add_mul;
    import mul_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [DATA_W-1:0] mcand_i = '0, mplier_i = '0;
    logic [IDX_W-1:0]  rd_i = '0;
    logic busy_o, done_o;
    logic [DATA_W-1:0] prod_hi_o, prod_lo_o;
    logic [IDX_W-1:0]  rd_even_o, rd_odd_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_add_mul dut (
        .clk(clk), .rst(rst), .start_i(start_i), .mcand_i(mcand_i),
        .mplier_i(mplier_i), .rd_i(rd_i), .busy_o(busy_o), .done_o(done_o),
        .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o),
        .rd_even_o(rd_even_o), .rd_odd_o(rd_odd_o)
    );

    // Behavioural reference model
    bit m_busy = 0, m_done = 0;
    int m_left = 0;
    logic [PROD_W-1:0] m_prod = '0, m_pend = '0;
    int m_even = 0, m_odd = 1;

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_busy = 0; m_done = 0; m_left = 0; m_prod = '0;
            m_even = 0; m_odd = 1;
        end else begin
            m_done = 0;
            if (m_busy) begin
                // R6: a start here is ignored by the model
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_prod = m_pend;
                end
            end else if (start_i) begin
                m_busy = 1; m_left = DATA_W;
                m_pend = {16'b0, mcand_i} * {16'b0, mplier_i};
                m_even = int'(rd_i) & ~1;
                m_odd  = m_even ^ 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (started) begin
            chk(busy_o == m_busy, "R2/R3 busy", busy_o, m_busy);
            chk(done_o == m_done, "R3/R8 done", done_o, m_done);
            chk(int'(rd_even_o) == m_even, "R5 even index", rd_even_o, m_even);
            chk(int'(rd_odd_o) == m_odd, "R5 odd index", rd_odd_o, m_odd);
            if (!m_busy) begin
                // R4 product on done, R7 hold while idle, R1 zero after reset
                chk({prod_hi_o, prod_lo_o} == m_prod, "R4/R7 product",
                    {prod_hi_o, prod_lo_o}, m_prod);
            end
        end
        if (cycles > WATCHDOG) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Drive start for one cycle, then idle for gap cycles
    task automatic issue(input logic [15:0] a, input logic [15:0] b,
                         input logic [3:0] rd, input int gap);
        @(negedge clk);
        start_i = 1'b1; mcand_i = a; mplier_i = b; rd_i = rd;
        @(negedge clk);
        start_i = 1'b0; mcand_i = ~a; mplier_i = ~b; rd_i = ~rd;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(prod_hi_o == 0 && prod_lo_o == 0, "R1 reset product", {prod_hi_o, prod_lo_o}, 0);
        chk(rd_even_o == 0 && rd_odd_o == 1, "R1 reset index", {rd_even_o, rd_odd_o}, 1);
        issue(16'h0000, 16'h0000, 4'd2, 18);
        issue(16'hFFFF, 16'hFFFF, 4'd4, 18);
        issue(16'h0001, 16'hFFFF, 4'd7, 18);   // R5 odd request
        issue(16'h1234, 16'h5678, 4'd15, 18);
        issue(16'hFFFF, 16'h0000, 4'd9, 18);
        issue(16'h8000, 16'h8000, 4'd0, 18);
        // R6: a second start while busy, with other operands and index
        issue(16'h00FF, 16'h0F0F, 4'd6, 5);
        issue(16'hAAAA, 16'h5555, 4'd11, 20);
        // R9: back to back, the second start lands in the done cycle
        issue(16'h0003, 16'h0005, 4'd12, 15);
        issue(16'hBEEF, 16'hCAFE, 4'd13, 18);
        for (int i = 0; i < 20; i++) begin
            issue(16'($urandom), 16'($urandom), 4'($urandom), 16 + (i % 4));
        end
        repeat (25) @(negedge clk);   // R7: hold while idle
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule